// File: doc/BRIEF.md
# Bus-Controller Interrupt Register Block

This block holds the interrupt state of a register-bus controller. Two event sources feed it as single-cycle pulses. Source 1 is a target that overran the programmable timeout. Source 0 is a target that answered with an error acknowledge. Each source has a sticky pending flag and an enable bit. The block drives one combined interrupt line: it is high while some source is both pending and enabled.

Software reaches the block through a plain 32-bit register port. Writes take effect on the clock edge, and reads are combinational on the address. Each enable bit can be changed in three ways: by a direct read/write register, by a write-one-to-set alias, or by a write-one-to-clear alias. Pending flags are never cleared by reading them. They are cleared only by writing ones to a dedicated clear register.

The register layout is five word offsets:
- 0x00: enable (read/write).
- 0x04: enable-set (write-only).
- 0x08: enable-clear (write-only).
- 0x0C: status (read-only).
- 0x10: pending-clear (write-only).

In every register, bit 1 is the timeout source and bit 0 is the error source. On the `src_evt` input, bit 1 is the timeout pulse and bit 0 is the error pulse.

Top module: `bcirq_regs`

## Requirements
- R1: After a clocked reset with `rst_n` low, every enable bit, every pending bit and `irq` are 0.
- R2: A write to offset 0x00 loads enable bits [1:0] from the write data. A read of 0x00 returns the enable bits in [1:0].
- R3: A write to offset 0x04 sets each enable bit whose data bit is 1. Enable bits whose data bit is 0 keep their value.
- R4: A write to offset 0x08 clears each enable bit whose data bit is 1. Enable bits whose data bit is 0 keep their value.
- R5: A read of offset 0x0C returns the pending bits in [1:0], whether or not the source is enabled. Writes to 0x0C change nothing.
- R6: A high cycle on `src_evt[i]` sets pending bit i. The bit then stays set until software clears it.
- R7: A write to offset 0x10 clears each pending bit whose data bit is 1. Pending bits whose data bit is 0 keep their value.
- R8: If an event pulse and a pending-clear for the same bit fall in the same cycle, the bit stays pending.
- R9: `irq` is registered and equals the OR over sources of (pending AND enable) as they stood one cycle earlier.
- R10: Reads of offsets 0x04, 0x08 and 0x10 return zero. Reads of any unmapped address return zero. Bits 31:2 of every read are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational on `bus_addr` |
| src_evt | input | 2 | Event pulses: bit 1 timeout, bit 0 error |
| irq | output | 1 | Combined interrupt, registered |

## Verification
The bench builds the block with its defaults: two sources and an 8-bit address. With two sources, every mix of pending, enable and clear data can be reached by random stimulus. The addresses are drawn across 0x00 to 0x1C, so the unmapped words beyond the map are hit along with all five registers. Directed steps cover three cases: an event landing together with its own clear, zero-data writes to the alias registers, and the one-cycle lag of `irq`.

// File: rtl/bcirq_pkg.sv
// Package: shared register offsets for the bus-controller interrupt block.
// Assumes word-aligned byte offsets within a small local window.
package bcirq_pkg;
    localparam int unsigned OFS_EN     = 'h00;
    localparam int unsigned OFS_EN_SET = 'h04;
    localparam int unsigned OFS_EN_CLR = 'h08;
    localparam int unsigned OFS_STAT   = 'h0C;
    localparam int unsigned OFS_PCLR   = 'h10;

    typedef struct packed {
        logic en_dir;
        logic en_set;
        logic en_clr;
        logic pend_clr;
    } wr_strobe_t;
endpackage

// File: rtl/bcirq_decode.sv
// Module: address decoder. Turns a write strobe and an address into one
// register-specific strobe, and flags which readable register is selected.
// Assumes exact address match; any other address selects nothing.
module bcirq_decode
    import bcirq_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    output wr_strobe_t        stb,
    output logic              rd_en_sel,
    output logic              rd_stat_sel
);
    // Purpose: match the address against each register offset.
    always_comb begin
        stb.en_dir   = wr && (addr == ADDR_W'(OFS_EN));
        stb.en_set   = wr && (addr == ADDR_W'(OFS_EN_SET));
        stb.en_clr   = wr && (addr == ADDR_W'(OFS_EN_CLR));
        stb.pend_clr = wr && (addr == ADDR_W'(OFS_PCLR));
        rd_en_sel    = (addr == ADDR_W'(OFS_EN));
        rd_stat_sel  = (addr == ADDR_W'(OFS_STAT));
    end

    // R2: at most one register is written per cycle
    p_one_target_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({stb.en_dir, stb.en_set, stb.en_clr, stb.pend_clr}));
endmodule

// File: rtl/bcirq_src_cell.sv
// Module: state of one interrupt source, holding its enable bit and its
// sticky pending bit. Assumes the strobes come from a decoder that fires
// at most one register strobe per cycle.
module bcirq_src_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic en_dir_we,
    input  logic en_dir_val,
    input  logic en_set,
    input  logic en_clr,
    input  logic pend_clr,
    input  logic evt,
    output logic en_q,
    output logic pend_q
);
    // Purpose: update the enable bit through its three access paths.
    always_ff @(posedge clk) begin
        if (!rst_n)         en_q <= 1'b0;
        else if (en_dir_we) en_q <= en_dir_val;
        else if (en_set)    en_q <= 1'b1;
        else if (en_clr)    en_q <= 1'b0;
    end

    // Purpose: sticky pending bit; an event beats a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)        pend_q <= 1'b0;
        else if (evt)      pend_q <= 1'b1;
        else if (pend_clr) pend_q <= 1'b0;
    end

    p_set_alias_r3: assert property (@(posedge clk) disable iff (!rst_n)
        en_set |=> en_q);
    p_clr_alias_r4: assert property (@(posedge clk) disable iff (!rst_n)
        en_clr |=> !en_q);
    p_evt_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> pend_q);
    p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !pend_clr) |=> pend_q);
    p_pclr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_clr && !evt) |=> !pend_q);
    p_evt_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_clr && evt) |=> pend_q);
endmodule

// File: rtl/bcirq_regs.sv
// Module: top of the interrupt register block. It decodes the register
// port, keeps one state cell per source, muxes read data and registers
// the combined interrupt line. Assumes NSRC is below 32.
module bcirq_regs
    import bcirq_pkg::*;
#(
    parameter int unsigned NSRC   = 2,
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NSRC-1:0]   src_evt,
    output logic              irq
);
    wr_strobe_t      stb;
    logic            rd_en_sel;
    logic            rd_stat_sel;
    logic [NSRC-1:0] en_q;
    logic [NSRC-1:0] pend_q;
    logic            unused_wdata;

    assign unused_wdata = ^bus_wdata[DATA_W-1:NSRC];

    bcirq_decode #(.ADDR_W(ADDR_W)) u_dec (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr          (bus_wr),
        .addr        (bus_addr),
        .stb         (stb),
        .rd_en_sel   (rd_en_sel),
        .rd_stat_sel (rd_stat_sel)
    );

    for (genvar gi = 0; gi < NSRC; gi++) begin : g_src
        bcirq_src_cell u_cell (
            .clk        (clk),
            .rst_n      (rst_n),
            .en_dir_we  (stb.en_dir),
            .en_dir_val (bus_wdata[gi]),
            .en_set     (stb.en_set & bus_wdata[gi]),
            .en_clr     (stb.en_clr & bus_wdata[gi]),
            .pend_clr   (stb.pend_clr & bus_wdata[gi]),
            .evt        (src_evt[gi]),
            .en_q       (en_q[gi]),
            .pend_q     (pend_q[gi])
        );
    end

    // Purpose: return enable or status bits; everything else reads zero.
    always_comb begin
        bus_rdata = '0;
        if (rd_en_sel)   bus_rdata[NSRC-1:0] = en_q;
        if (rd_stat_sel) bus_rdata[NSRC-1:0] = pend_q;
    end

    // Purpose: register the combined interrupt line.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= |(pend_q & en_q);
    end

    p_irq_lag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_q & en_q) != '0) |=> irq);
    p_irq_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_q & en_q) == '0) |=> !irq);
    p_rd_upper_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[DATA_W-1:NSRC] == '0);
endmodule

// File: tb/bcirq_regs_test.sv
module bcirq_regs_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] A_EN = 8'h00, A_SET = 8'h04, A_CLR = 8'h08,
                           A_STAT = 8'h0C, A_PCLR = 8'h10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  src_evt = '0;
    logic        irq;

    int total = 0;
    int bad = 0;
    logic [1:0] m_en = '0, m_pend = '0;
    logic       m_irq = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bcirq_regs uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_evt(src_evt),
        .irq(irq)
    );

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        if (a == A_EN)   return {30'd0, m_en};
        if (a == A_STAT) return {30'd0, m_pend};
        return 32'd0;
    endfunction

    function automatic string tag_of(input logic [7:0] a);
        case (a)
            A_EN:    return "R2";
            A_STAT:  return "R5";
            default: return "R10";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One cycle: drive at negedge, update the model at posedge, check after.
    task automatic step(input logic w, input logic [7:0] a, input logic [31:0] d,
                        input logic [1:0] e);
        @(negedge clk);
        bus_wr = w; bus_addr = a; bus_wdata = d; src_evt = e;
        @(posedge clk);
        m_irq = |(m_pend & m_en);
        if (w) begin
            case (a)
                A_EN:   m_en = d[1:0];
                A_SET:  m_en = m_en | d[1:0];
                A_CLR:  m_en = m_en & ~d[1:0];
                A_PCLR: m_pend = m_pend & ~d[1:0];
                default: ;
            endcase
        end
        m_pend = m_pend | e;
        #1;
        chk("R9", {31'd0, irq}, {31'd0, m_irq});
        chk(tag_of(a), bus_rdata, exp_read(a));
    endtask

    task automatic rd(input logic [7:0] a, input string tag);
        step(1'b0, a, 32'd0, 2'b00);
        chk(tag, bus_rdata, exp_read(a));
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd4242);
        repeat (3) @(posedge clk);
        #1;
        chk("R1 irq", {31'd0, irq}, 32'd0);
        @(negedge clk); rst_n = 1'b1;
        rd(A_EN, "R1 en");
        rd(A_STAT, "R1 pend");

        // R2 direct enable write, R5 status while disabled
        step(1'b1, A_EN, 32'hFFFF_FFFE, 2'b00);
        rd(A_EN, "R2");
        step(1'b0, A_STAT, 32'd0, 2'b01);
        rd(A_STAT, "R5 shown while disabled");
        chk("R9 disabled", {31'd0, irq}, 32'd0);
        // R3 set alias; zero bits keep the value
        step(1'b1, A_SET, 32'd1, 2'b00);
        chk("R9 lag", {31'd0, irq}, 32'd0);
        step(1'b0, A_EN, 32'd0, 2'b00);
        chk("R9 rise", {31'd0, irq}, 32'd1);
        step(1'b1, A_SET, 32'd0, 2'b00);
        rd(A_EN, "R3 zero write");
        // R4 clear alias
        step(1'b1, A_CLR, 32'd2, 2'b00);
        rd(A_EN, "R4");
        step(1'b1, A_CLR, 32'd0, 2'b00);
        rd(A_EN, "R4 zero write");
        // R5 write to status ignored
        step(1'b1, A_STAT, 32'd0, 2'b10);
        step(1'b1, A_STAT, 32'd0, 2'b00);
        rd(A_STAT, "R5 write ignored");
        // R8 event together with its own clear
        step(1'b1, A_PCLR, 32'd3, 2'b10);
        rd(A_STAT, "R8");
        // R7 clear with zero data, then real clear; R6 sticky across cycles
        step(1'b1, A_PCLR, 32'd0, 2'b00);
        rd(A_STAT, "R6 sticky");
        step(1'b1, A_PCLR, 32'd2, 2'b00);
        rd(A_STAT, "R7");
        // R10 write-only and unmapped reads
        rd(A_SET, "R10 set");
        rd(A_PCLR, "R10 pclr");
        rd(8'h1C, "R10 unmapped");

        for (int i = 0; i < 400; i++) begin
            logic [7:0] a;
            a = 8'(($urandom % 8) * 4);
            step(($urandom % 3) != 0, a, $urandom, 2'($urandom % 4 == 0 ? $urandom : 0));
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule